// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This block is the memory access stage of a 32-bit register-based processor. Each request carries a decoded access type, a base register value, a 16-bit signed offset, the value to store and a destination register index. The unit adds the sign-extended offset to the base to form the effective address. It then presents one access on a single-cycle synchronous memory bus: an address, a per-lane byte-enable mask, write data and separate read and write strobes.

For stores, the low byte, the low halfword or the whole word of the source value is copied onto the lanes that the address selects. For loads, the returned word has the addressed byte or halfword picked out of it (little-endian lane order). That value is zero- or sign-extended as the access type asks, then driven on a write-back port aimed at the register file. Load results are delivered one request late: the instruction issued directly after a load never observes the loaded value. Accesses that are not naturally aligned are flagged and dropped. A load aimed at register 0 never writes back.

Top module: `lsalign_top`

## Requirements
- R1: One cycle after a request is accepted, `bus_addr` equals `req_base` plus `req_offset` sign-extended to 32 bits, with wrap-around modulo 2^32.
- R2: A byte store (`req_size` 2'b00) drives the source's low byte on all four lanes of `bus_wdata`. It sets only `bus_be` bit `addr[1:0]` and raises `bus_we`.
- R3: A halfword store (`req_size` 2'b01) drives the source's low halfword on both halves of `bus_wdata`. `bus_be` is 4'b1100 when `addr[1]` is 1 and 4'b0011 otherwise.
- R4: A word store (`req_size` 2'b10, with 2'b11 treated the same) drives the whole source value with `bus_be` 4'b1111.
- R5: An aligned load raises `bus_re` and not `bus_we`, with `bus_be` marking the lanes read. In the following cycle, `wb_en` is 1 and `wb_idx` equals the request's destination. In the cycle when the load's bus access is presented, the write-back port shows nothing for it (delay slot).
- R6: A byte load returns the lane `addr[1:0]` (lane 0 = bits 7:0). The value is sign-extended when `req_unsigned` is 0 and zero-extended when it is 1.
- R7: A halfword load returns bits 31:16 when `addr[1]` is 1 and bits 15:0 otherwise, extended per `req_unsigned` as in R6.
- R8: A word load returns the read word unchanged, whatever `req_unsigned` is.
- R9: A halfword access with `addr[0]`=1, or a word access with `addr[1:0]`≠0, sets `misalign` for one cycle. In that cycle `bus_we`, `bus_re` and `bus_be` are all 0, and no write-back follows.
- R10: A load whose destination index is 0 produces no write-back (`wb_en` stays 0).
- R11: After reset, all bus strobes, `bus_be`, `bus_addr`, `misalign` and `wb_en` are 0.
- R12: A cycle following no request has `bus_we`, `bus_re` and `misalign` at 0, with `bus_addr` unchanged.
- R13: Back-to-back requests are accepted every cycle. A load followed at once by another load writes back both in order. A load directly after a store to the same word returns the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_unsigned | input | 1 | Zero-extend loaded byte/halfword |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed immediate offset |
| req_wval | input | 32 | Source register value for stores |
| req_dest | input | 5 | Destination register index for loads |
| bus_addr | output | 32 | Effective address |
| bus_be | output | 4 | Byte-lane enable mask |
| bus_wdata | output | 32 | Lane-steered write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | 32 | Read data, valid the cycle after `bus_re` |
| misalign | output | 1 | Unaligned access dropped |
| wb_en | output | 1 | Register write-back valid |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Extended load result |

## Verification
The bench builds the unit with its default parameters: 32-bit data, a 16-bit offset and 5-bit register indices. These defaults bring all four byte lanes, both halfword positions and a real sign bit in the offset within reach. Random bases and offsets, including negative offsets and wrap-around sums, land every access in a 1 KiB bench memory. Directed sequences cover the back-to-back load pair and the store-then-load forwarding through memory. Register index 0 and all misaligned offsets for each size are drawn often enough to be hit many times.

// File: rtl/lsalign_pkg.sv
package lsalign_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  // Size code 2'b11 is folded onto a full-width access.
  function automatic acc_size_e decode_size(input logic [1:0] code);
    case (code)
      2'b00:   return SZ_BYTE;
      2'b01:   return SZ_HALF;
      default: return SZ_WORD;
    endcase
  endfunction

endpackage

// File: rtl/lsalign_agen.sv
module lsalign_agen #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  base,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  ea
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign ea      = base + imm_ext;
endmodule

// File: rtl/lsalign_store_lanes.sv
module lsalign_store_lanes
  import lsalign_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  acc_size_e                      size,
  input  logic [$clog2(XLEN/8)-1:0]      lane_off,
  input  logic [XLEN-1:0]                src,
  output logic [XLEN-1:0]                wdata,
  output logic [XLEN/8-1:0]              be,
  output logic                           unaligned
);
  localparam int NLANES = XLEN / 8;
  localparam int OFF_W  = $clog2(NLANES);

  for (genvar i = 0; i < NLANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] BYTE_SEL = OFF_W'(i);
    localparam logic [OFF_W-2:0] HALF_SEL = (OFF_W-1)'(i / 2);

    assign wdata[8*i +: 8] = (size == SZ_BYTE) ? src[7:0] :
                             (size == SZ_HALF) ? src[8*(i%2) +: 8] :
                                                 src[8*i +: 8];

    assign be[i] = (size == SZ_BYTE) ? (lane_off == BYTE_SEL) :
                   (size == SZ_HALF) ? (lane_off[OFF_W-1:1] == HALF_SEL) :
                                       1'b1;
  end

  assign unaligned = ((size == SZ_HALF) && lane_off[0]) ||
                     ((size == SZ_WORD) && (lane_off != '0));
endmodule

// File: rtl/lsalign_load_extract.sv
module lsalign_load_extract
  import lsalign_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]            rdata,
  input  acc_size_e                  size,
  input  logic                       zext,
  input  logic [$clog2(XLEN/8)-1:0]  lane_off,
  output logic [XLEN-1:0]            value
);
  localparam int OFF_W = $clog2(XLEN / 8);

  logic [7:0]  byte_v;
  logic [15:0] half_v;
  logic        byte_fill;
  logic        half_fill;

  always_comb begin
    byte_v    = rdata[{lane_off, 3'b000} +: 8];
    half_v    = rdata[{lane_off[OFF_W-1:1], 4'b0000} +: 16];
    byte_fill = !zext && byte_v[7];
    half_fill = !zext && half_v[15];
    case (size)
      SZ_BYTE: value = {{(XLEN-8){byte_fill}}, byte_v};
      SZ_HALF: value = {{(XLEN-16){half_fill}}, half_v};
      default: value = rdata;
    endcase
  end
endmodule

// File: rtl/lsalign_top.sv
module lsalign_top
  import lsalign_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int IMM_W  = 16,
  parameter int RIDX_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [1:0]           req_size,
  input  logic                 req_unsigned,
  input  logic [XLEN-1:0]      req_base,
  input  logic [IMM_W-1:0]     req_offset,
  input  logic [XLEN-1:0]      req_wval,
  input  logic [RIDX_W-1:0]    req_dest,
  output logic [XLEN-1:0]      bus_addr,
  output logic [XLEN/8-1:0]    bus_be,
  output logic [XLEN-1:0]      bus_wdata,
  output logic                 bus_we,
  output logic                 bus_re,
  input  logic [XLEN-1:0]      bus_rdata,
  output logic                 misalign,
  output logic                 wb_en,
  output logic [RIDX_W-1:0]    wb_idx,
  output logic [XLEN-1:0]      wb_data
);
  localparam int NLANES = XLEN / 8;
  localparam int OFF_W  = $clog2(NLANES);

  // request-side decode
  acc_size_e          req_sz;
  logic [XLEN-1:0]    ea;
  logic [XLEN-1:0]    steer_data;
  logic [NLANES-1:0]  steer_be;
  logic               steer_bad;
  logic               go;

  // stage A: load context travelling with the bus cycle
  logic               pa_load;
  logic [RIDX_W-1:0]  pa_idx;
  acc_size_e          pa_size;
  logic               pa_zext;
  logic [OFF_W-1:0]   pa_off;

  // stage B: write-back context, aligned with returned read data
  acc_size_e          pb_size;
  logic               pb_zext;
  logic [OFF_W-1:0]   pb_off;
  logic [XLEN-1:0]    ext_val;

  assign req_sz = decode_size(req_size);

  lsalign_agen #(.XLEN(XLEN), .IMM_W(IMM_W)) agen_i (
    .base (req_base),
    .imm  (req_offset),
    .ea   (ea)
  );

  lsalign_store_lanes #(.XLEN(XLEN)) steer_i (
    .size      (req_sz),
    .lane_off  (ea[OFF_W-1:0]),
    .src       (req_wval),
    .wdata     (steer_data),
    .be        (steer_be),
    .unaligned (steer_bad)
  );

  assign go = req_valid && !steer_bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_be    <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      misalign  <= 1'b0;
      pa_load   <= 1'b0;
      pa_idx    <= '0;
      pa_size   <= SZ_WORD;
      pa_zext   <= 1'b0;
      pa_off    <= '0;
    end else begin
      if (req_valid) begin
        bus_addr <= ea;
      end
      misalign  <= req_valid && steer_bad;
      bus_we    <= go && req_store;
      bus_re    <= go && !req_store;
      bus_be    <= go ? steer_be : '0;
      bus_wdata <= (go && req_store) ? steer_data : '0;
      pa_load   <= go && !req_store && (req_dest != '0);
      pa_idx    <= req_dest;
      pa_size   <= req_sz;
      pa_zext   <= req_unsigned;
      pa_off    <= ea[OFF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_en   <= 1'b0;
      wb_idx  <= '0;
      pb_size <= SZ_WORD;
      pb_zext <= 1'b0;
      pb_off  <= '0;
    end else begin
      wb_en   <= pa_load;
      wb_idx  <= pa_load ? pa_idx : '0;
      pb_size <= pa_size;
      pb_zext <= pa_zext;
      pb_off  <= pa_off;
    end
  end

  lsalign_load_extract #(.XLEN(XLEN)) extract_i (
    .rdata    (bus_rdata),
    .size     (pb_size),
    .zext     (pb_zext),
    .lane_off (pb_off),
    .value    (ext_val)
  );

  assign wb_data = wb_en ? ext_val : '0;
endmodule

// File: rtl/lsalign_checker.sv
module lsalign_checker #(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                req_valid,
  input logic [XLEN-1:0]     bus_addr,
  input logic [XLEN/8-1:0]   bus_be,
  input logic                bus_we,
  input logic                bus_re,
  input logic                misalign,
  input logic                wb_en,
  input logic [RIDX_W-1:0]   wb_idx
);
  localparam int NLANES = XLEN / 8;

  logic armed = 1'b0;
  logic prev_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed      <= 1'b1;
      prev_valid <= 1'b0;
    end else begin
      prev_valid <= req_valid;
    end
  end

  // R9: a dropped access touches nothing on the bus
  a_r9_misalign_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
    misalign |-> (!bus_we && !bus_re && bus_be == '0));

  // R10: register 0 is never a write-back target
  a_r10_no_zero_wb: assert property (@(posedge clk) disable iff (rst || !armed)
    wb_en |-> (wb_idx != '0));

  // R5: a write-back only follows a bus read one cycle earlier
  a_r5_wb_after_read: assert property (@(posedge clk) disable iff (rst || !armed)
    wb_en |-> $past(bus_re));

  // R5: read and write strobes never together
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (rst || !armed)
    !(bus_we && bus_re));

  // R2/R3/R4: a write enables one, two or all lanes
  a_r2_store_lane_count: assert property (@(posedge clk) disable iff (rst || !armed)
    bus_we |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 ||
                $countones(bus_be) == NLANES));

  // R12: idle cycle leaves the bus quiet and the address held
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst || !armed)
    !prev_valid |-> (!bus_we && !bus_re && !misalign));

  a_r12_addr_held: assert property (@(posedge clk) disable iff (rst || !armed)
    (!prev_valid && !$past(rst)) |-> $stable(bus_addr));
endmodule

bind lsalign_top lsalign_checker #(.XLEN(XLEN), .RIDX_W(RIDX_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .misalign  (misalign),
  .wb_en     (wb_en),
  .wb_idx    (wb_idx)
);

// File: tb/lsalign_top_tb_top.sv
`timescale 1ns/1ps
module lsalign_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_unsigned = 1'b0;
  logic [31:0] req_base = '0;
  logic [15:0] req_offset = '0;
  logic [31:0] req_wval = '0;
  logic [4:0]  req_dest = '0;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, wb_data;
  logic [3:0]  bus_be;
  logic        bus_we, bus_re, misalign, wb_en;
  logic [4:0]  wb_idx;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lsalign_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_offset(req_offset), .req_wval(req_wval), .req_dest(req_dest),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .misalign(misalign), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  // bench memory: 256 words, synchronous read one cycle after address
  logic [31:0] ram [0:255];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) ram[i] <= (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
      bus_rdata <= '0;
    end else begin
      if (bus_we)
        for (int l = 0; l < 4; l++)
          if (bus_be[l]) ram[bus_addr[9:2]][8*l +: 8] <= bus_wdata[8*l +: 8];
      bus_rdata <= ram[bus_addr[9:2]];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] eff_addr(input logic [31:0] b, input logic [15:0] o);
    return b + {{16{o[15]}}, o};
  endfunction

  function automatic bit is_bad(input logic [1:0] sz, input logic [1:0] lo);
    return (sz == 2'b01 && lo[0]) || (sz[1] && lo != 2'b00);
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lo);
    if (is_bad(sz, lo)) return 4'h0;
    if (sz == 2'b00) return 4'b0001 << lo;
    if (sz == 2'b01) return lo[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] exp_wdata(input logic [1:0] sz, input logic [31:0] v);
    if (sz == 2'b00) return {4{v[7:0]}};
    if (sz == 2'b01) return {2{v[15:0]}};
    return v;
  endfunction

  function automatic logic [31:0] exp_load(input logic [31:0] w, input logic [1:0] sz,
                                           input logic u, input logic [1:0] lo);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*lo +: 8];
    h = lo[1] ? w[31:16] : w[15:0];
    if (sz == 2'b00) return u ? {24'h0, b} : {{24{b[7]}}, b};
    if (sz == 2'b01) return u ? {16'h0, h} : {{16{h[15]}}, h};
    return w;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] w, input logic [1:0] sz,
                                        input logic [1:0] lo, input logic [31:0] v);
    logic [3:0]  m;
    logic [31:0] d, r;
    m = exp_be(sz, lo);
    d = exp_wdata(sz, v);
    r = w;
    for (int l = 0; l < 4; l++) if (m[l]) r[8*l +: 8] = d[8*l +: 8];
    return r;
  endfunction

  task automatic drive(input bit st, input logic [1:0] sz, input bit u, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] v, input logic [4:0] d);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = u;
    req_base = b; req_offset = o; req_wval = v; req_dest = d;
  endtask

  // one isolated request, checked at its bus cycle and its write-back cycle
  task automatic do_op(input bit st, input logic [1:0] sz, input bit u, input logic [31:0] b,
                       input logic [15:0] o, input logic [31:0] v, input logic [4:0] d);
    logic [31:0] ea, oldw, held;
    bit bad;
    ea   = eff_addr(b, o);
    bad  = is_bad(sz, ea[1:0]);
    oldw = ram[ea[9:2]];
    @(negedge clk);
    drive(st, sz, u, b, o, v, d);
    @(posedge clk); #1;
    check("R1 bus_addr", bus_addr, ea);
    check("R9 misalign", {31'h0, misalign}, {31'h0, bad});
    check(st ? "R2/R3/R4 bus_be" : "R5 bus_be", {28'h0, bus_be}, {28'h0, exp_be(sz, ea[1:0])});
    check("R9 bus_we", {31'h0, bus_we}, {31'h0, st && !bad});
    check("R5 bus_re", {31'h0, bus_re}, {31'h0, !st && !bad});
    if (st && !bad) check(sz == 2'b00 ? "R2 wdata" : (sz == 2'b01 ? "R3 wdata" : "R4 wdata"),
                          bus_wdata, exp_wdata(sz, v));
    check("R5 delay slot wb_en", {31'h0, wb_en}, 32'h0);
    held = bus_addr;
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
    check("R12 idle strobes", {30'h0, bus_we, bus_re}, 32'h0);
    check("R12 addr held", bus_addr, held);
    if (!st && !bad && d != 0) begin
      check("R5 wb_en", {31'h0, wb_en}, 32'h1);
      check("R5 wb_idx", {27'h0, wb_idx}, {27'h0, d});
      check(sz == 2'b00 ? "R6 byte load" : (sz == 2'b01 ? "R7 half load" : "R8 word load"),
            wb_data, exp_load(oldw, sz, u, ea[1:0]));
    end else begin
      check(d == 0 ? "R10 no wb to r0" : "R9 no wb", {31'h0, wb_en}, 32'h0);
    end
  endtask

  initial begin
    int unsigned seed_v;
    logic [31:0] ea, w0, w1, b;
    logic [15:0] o;
    seed_v = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset strobes", {29'h0, bus_we, bus_re, misalign}, 32'h0);
    check("R11 reset be/wb", {27'h0, bus_be, wb_en}, 32'h0);
    check("R11 reset addr", bus_addr, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    // directed corners
    do_op(1'b1, 2'b00, 1'b0, 32'h0000_0103, 16'h0000, 32'h1234_56A7, 5'd1); // R2 lane 3
    do_op(1'b0, 2'b00, 1'b0, 32'h0000_0103, 16'h0000, 32'h0, 5'd2);         // R6 signed
    do_op(1'b0, 2'b00, 1'b1, 32'h0000_0103, 16'h0000, 32'h0, 5'd2);         // R6 unsigned
    do_op(1'b1, 2'b01, 1'b0, 32'h0000_0210, 16'hFFF2, 32'hAAAA_8001, 5'd1); // R3 upper, neg off
    do_op(1'b0, 2'b01, 1'b0, 32'h0000_0210, 16'hFFF2, 32'h0, 5'd7);         // R7 signed
    do_op(1'b0, 2'b01, 1'b1, 32'h0000_0210, 16'hFFF2, 32'h0, 5'd7);         // R7 unsigned
    do_op(1'b1, 2'b11, 1'b0, 32'hFFFF_FFF0, 16'h0020, 32'hDEAD_BEEF, 5'd1); // R4 code 11, wrap R1
    do_op(1'b0, 2'b10, 1'b1, 32'hFFFF_FFF0, 16'h0020, 32'h0, 5'd31);        // R8
    do_op(1'b0, 2'b10, 1'b0, 32'h0000_0040, 16'h0000, 32'h0, 5'd0);         // R10
    do_op(1'b0, 2'b01, 1'b0, 32'h0000_0041, 16'h0000, 32'h0, 5'd3);         // R9 half odd
    do_op(1'b1, 2'b10, 1'b0, 32'h0000_0042, 16'h0000, 32'h1, 5'd3);         // R9 word
    do_op(1'b1, 2'b01, 1'b0, 32'h0000_0047, 16'h0000, 32'h1, 5'd3);         // R9 half store

    // R13: back-to-back loads
    w0 = ram[8'h21]; w1 = ram[8'h22];
    @(negedge clk); drive(1'b0, 2'b00, 1'b0, 32'h0000_0086, 16'h0000, 32'h0, 5'd3);
    @(negedge clk); drive(1'b0, 2'b01, 1'b1, 32'h0000_0088, 16'h0002, 32'h0, 5'd4);
    @(posedge clk); #1;
    check("R13 first wb_idx", {26'h0, wb_en, wb_idx}, {26'h0, 1'b1, 5'd3});
    check("R13 first wb_data", wb_data, exp_load(w0, 2'b00, 1'b0, 2'd2));
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    check("R13 second wb_idx", {26'h0, wb_en, wb_idx}, {26'h0, 1'b1, 5'd4});
    check("R13 second wb_data", wb_data, exp_load(w1, 2'b01, 1'b1, 2'd2));

    // R13: store then load of the same word, back to back
    w0 = merge(ram[8'h30], 2'b00, 2'd1, 32'h0000_00C3);
    @(negedge clk); drive(1'b1, 2'b00, 1'b0, 32'h0000_00C1, 16'h0000, 32'h0000_00C3, 5'd1);
    @(negedge clk); drive(1'b0, 2'b10, 1'b0, 32'h0000_00C0, 16'h0000, 32'h0, 5'd9);
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    check("R13 store-then-load", wb_data, w0);
    @(posedge clk); #1;

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [1:0] sz;
      sz = 2'($urandom_range(0, 3));
      ea = 32'($urandom_range(0, 1023));
      if ($urandom_range(0, 3) != 0) begin
        if (sz == 2'b01) ea[0] = 1'b0;
        if (sz[1]) ea[1:0] = 2'b00;
      end
      o = 16'($urandom);
      b = ea - {{16{o[15]}}, o};
      do_op(1'($urandom_range(0, 1)), sz, 1'($urandom_range(0, 1)), b, o, $urandom,
            ($urandom_range(0, 7) == 0) ? 5'd0 : 5'($urandom_range(1, 31)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule